// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Port

This block is the digital side of a 12-bit successive-approximation converter that sits behind a three-wire serial port. The host drives an active-low select line and a data clock. The block drives one serial data line, which can be put into high impedance. A falling select holds the analog input and starts a conversion. The block then works out the result one bit per data-clock cycle. It sets a trial code on the DAC drive, reads one comparator bit and keeps or drops that trial bit. Each bit is sent out serially as soon as it has been decided.

The block samples the select and data-clock inputs with a fast system clock and acts on their edges. The data line stays in high impedance for the first data-clock fall. It is enabled on the second fall, which sends a zero null bit. The next twelve falls send the result, most significant bit first. If the host keeps clocking while the select line stays low, a parameter picks what follows. One choice sends the word again least significant bit first and then zeros. The other choice sends only zeros. Raising the select line at any point ends the session, disables the data line and raises the power-down flag. A session that is cut short keeps the bits already decided on the DAC drive.

Top module: `sadc_serial_if`

## Requirements
- R1: After reset the data-line enable is 0, the power-down flag is 1, the serial data is 0 and the DAC drive is 0.
- R2: After select falls, the first data-clock fall leaves the data-line enable at 0.
- R3: The second data-clock fall sets the enable to 1 and sends a null bit of value 0.
- R4: Falls 3 to 14 send the 12-bit straight-binary result, most significant bit first. The result is the largest code that the comparator reports as not above the held input, over the range 0 to 4095.
- R5: After fall k (2 to 13), the DAC drive holds the bits decided so far in positions 11 down to 14-k, a trial 1 in position 13-k, and zeros below it. After fall 14 it equals the result.
- R6: With the replay parameter set to 1, falls 15 to 25 send result bits 1 through 11 in that order, and every later fall sends 0.
- R7: With the replay parameter set to 0, every fall after the 14th sends 0.
- R8: While select is high, the data-line enable is 0 and the power-down flag is 1. Both change in the cycle after select has been seen to change.
- R9: Raising select before a conversion ends keeps the bits already decided on the DAC drive and clears the pending trial bit and all lower bits.
- R10: A new select fall clears the DAC drive. The new conversion starts at mid-scale (0x800) no matter how many clocks the previous session had.
- R11: Data-clock edges while select is high change neither the data line, its enable nor the DAC drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Active-low select, already synchronous to clk |
| dclk_i | input | 1 | Host data clock, already synchronous to clk |
| comp_i | input | 1 | Comparator bit, 1 when the held input is not below the DAC drive |
| dac_o | output | 12 | Trial or result code driven to the capacitive DAC |
| dout_o | output | 1 | Serial data bit |
| doe_o | output | 1 | Data-line enable; 0 means high impedance |
| pd_o | output | 1 | Power-down flag, 1 while the port is not selected |

## Verification
The hardest case to reach from the ports is a session that ends early: select rises while a trial bit is still waiting for its comparator decision. The stimulus counts data-clock pulses so that select rises just after a chosen fall. It then reads the DAC drive, which should show the decided upper bits with the pending and lower bits cleared. Right after this, a full conversion with a different input checks that no state is carried into the next session. A second instance with the replay option turned off receives the same stimulus, so both tail behaviours are checked on the same edges.

// File: rtl/sadc_pkg.sv
// Shared types for the serial converter port.
// Assumes the per-session fall count k starts at 1 on the first
// data-clock fall after select goes low.
package sadc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_NULL,
        PH_DATA,
        PH_REPLAY,
        PH_ZERO
    } phase_e;

    // Returns the phase that data-clock fall number k belongs to.
    function automatic phase_e phase_of(input int k, input int res, input bit replay);
        if (k <= 0)                          return PH_IDLE;
        else if (k == 1)                     return PH_SAMPLE;
        else if (k == 2)                     return PH_NULL;
        else if (k <= res + 2)               return PH_DATA;
        else if (replay && (k <= 2*res + 1)) return PH_REPLAY;
        else                                 return PH_ZERO;
    endfunction

endpackage

// File: rtl/sadc_sync.sv
// Edge detector for the select and data-clock inputs.
// Assumes both inputs are already synchronous to clk. Provides the
// registered select level, the select start pulse and the data-clock
// rise and fall pulses.
module sadc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic dclk_i,
    output logic sel_o,
    output logic start_o,
    output logic dfall_o,
    output logic drise_o
);
    logic cs_q1, cs_q2, dk_q1, dk_q2;

    // Two-deep history of each input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q1 <= 1'b1;
            cs_q2 <= 1'b1;
            dk_q1 <= 1'b0;
            dk_q2 <= 1'b0;
        end else begin
            cs_q1 <= cs_n_i;
            cs_q2 <= cs_q1;
            dk_q1 <= dclk_i;
            dk_q2 <= dk_q1;
        end
    end

    assign sel_o   = ~cs_q1;
    assign start_o = cs_q2 & ~cs_q1;
    assign dfall_o = dk_q2 & ~dk_q1;
    assign drise_o = ~dk_q2 & dk_q1;
endmodule

// File: rtl/sadc_seq.sv
// Saturating counter of data-clock falls within one select session.
// Assumes start, sel and dfall come from sadc_sync. step_o marks a
// fall that counts, and knext_o is its fall number.
module sadc_seq #(
    parameter int RES = 12,
    localparam int KMAX = 2*RES + 2,
    localparam int CW = $clog2(KMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          start_i,
    input  logic          dfall_i,
    output logic          step_o,
    output logic [CW-1:0] knext_o,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt;

    assign knext_o = (cnt == CW'(KMAX)) ? cnt : cnt + 1'b1;
    assign step_o  = sel_i & ~start_i & dfall_i;
    assign cnt_o   = cnt;

    // Count falls while selected, and clear when idle or at a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (!sel_i || start_i) cnt <= '0;
        else if (step_o)           cnt <= knext_o;
    end
endmodule

// File: rtl/sadc_sar.sv
// Successive-approximation register.
// On fall k (2..RES+1) it sets a trial 1 at bit RES+1-k. On the next
// data-clock rise it keeps that bit or clears it, depending on the
// comparator. If select drops while a trial is pending, that trial bit
// is cleared and the decided upper bits stay.
module sadc_sar #(
    parameter int RES = 12,
    parameter int CW  = 5,
    localparam int IW = $clog2(RES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_i,
    input  logic           start_i,
    input  logic           step_i,
    input  logic           rise_i,
    input  logic [CW-1:0]  k_i,
    input  logic           comp_i,
    output logic [RES-1:0] sar_o
);
    logic [RES-1:0] sar;
    logic [IW-1:0]  idx, tidx;
    logic           pend, in_win;

    // Trial bit index and conversion window for this fall number.
    always_comb begin
        tidx   = IW'(RES + 1 - int'(k_i));
        in_win = (int'(k_i) >= 2) && (int'(k_i) <= RES + 1);
    end

    // Trial, decision and short-cycle cleanup of the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar  <= '0;
            idx  <= '0;
            pend <= 1'b0;
        end else if (start_i) begin
            sar  <= '0;
            pend <= 1'b0;
        end else if (!sel_i) begin
            if (pend) sar[idx] <= 1'b0;
            pend <= 1'b0;
        end else if (step_i && in_win) begin
            sar[tidx] <= 1'b1;
            idx       <= tidx;
            pend      <= 1'b1;
        end else if (rise_i && pend) begin
            if (!comp_i) sar[idx] <= 1'b0;
            pend <= 1'b0;
        end
    end

    assign sar_o = sar;

    AST_SAR_CLEAR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sar == '0)); // R10
    AST_SAR_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && !pend) |=> $stable(sar)); // R11
endmodule

// File: rtl/sadc_shift.sv
// Serial output framer.
// Assumes each counted fall carries its fall number k. It drives the
// null bit, the result MSB-first, an optional LSB-first replay and then
// zeros. The enable rises on fall 2 and drops whenever select is high.
module sadc_shift
    import sadc_pkg::*;
#(
    parameter int RES    = 12,
    parameter int CW     = 5,
    parameter bit REPLAY = 1'b1,
    localparam int IW = $clog2(RES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_i,
    input  logic           start_i,
    input  logic           step_i,
    input  logic [CW-1:0]  k_i,
    input  logic [RES-1:0] sar_i,
    output logic           dout_o,
    output logic           doe_o
);
    phase_e        ph;
    logic [IW-1:0] bidx;
    logic          nbit;

    // Choose the bit that goes out on this fall.
    always_comb begin
        ph   = phase_of(int'(k_i), RES, REPLAY);
        bidx = '0;
        nbit = 1'b0;
        if (ph == PH_DATA) begin
            bidx = IW'(RES + 2 - int'(k_i));
            nbit = sar_i[bidx];
        end else if (ph == PH_REPLAY) begin
            bidx = IW'(int'(k_i) - RES - 2);
            nbit = sar_i[bidx];
        end
    end

    // Launch bits on counted falls, and release the line when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_i || start_i) begin
            dout_o <= 1'b0;
            doe_o  <= 1'b0;
        end else if (step_i) begin
            if (ph == PH_NULL) doe_o <= 1'b1;
            dout_o <= nbit;
        end
    end

    AST_NULL_BIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(doe_o) |-> !dout_o); // R3
endmodule

// File: rtl/sadc_serial_if.sv
// Top level of the serial converter port.
// Assumes cs_n_i and dclk_i are synchronous to clk and that each
// data-clock phase lasts several clk cycles. The comparator is outside
// this block and reports the held input against dac_o.
module sadc_serial_if #(
    parameter int RES    = 12,
    parameter bit REPLAY = 1'b1,
    localparam int KMAX = 2*RES + 2,
    localparam int CW   = $clog2(KMAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n_i,
    input  logic           dclk_i,
    input  logic           comp_i,
    output logic [RES-1:0] dac_o,
    output logic           dout_o,
    output logic           doe_o,
    output logic           pd_o
);
    logic          sel, start, dfall, drise, step;
    logic [CW-1:0] knext, cnt;

    sadc_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .dclk_i(dclk_i),
        .sel_o(sel), .start_o(start), .dfall_o(dfall), .drise_o(drise)
    );

    sadc_seq #(.RES(RES)) u_seq (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .start_i(start),
        .dfall_i(dfall), .step_o(step), .knext_o(knext), .cnt_o(cnt)
    );

    sadc_sar #(.RES(RES), .CW(CW)) u_sar (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .start_i(start),
        .step_i(step), .rise_i(drise), .k_i(knext), .comp_i(comp_i),
        .sar_o(dac_o)
    );

    sadc_shift #(.RES(RES), .CW(CW), .REPLAY(REPLAY)) u_shift (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .start_i(start),
        .step_i(step), .k_i(knext), .sar_i(dac_o),
        .dout_o(dout_o), .doe_o(doe_o)
    );

    // Power-down flag follows the registered select level.
    always_ff @(posedge clk) begin
        if (!rst_n) pd_o <= 1'b1;
        else        pd_o <= ~sel;
    end

    AST_NO_DRIVE_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
        pd_o |-> !doe_o); // R8
    AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (doe_o && cnt == CW'(KMAX)) |-> !dout_o); // R6 R7
endmodule

// File: tb/sadc_serial_if_test.sv
// Directed bench: one task per scenario. Two instances share the select
// and clock lines, uut with replay on and uut_z with replay off.
module sadc_serial_if_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic dclk = 1'b0;
    logic [11:0] vin = '0;
    logic [11:0] dac, dac_z;
    logic dout, doe, pd, dout_z, doe_z, pd_z;
    logic comp, comp_z;
    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    assign comp   = (vin >= dac);
    assign comp_z = (vin >= dac_z);

    sadc_serial_if uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .dclk_i(dclk), .comp_i(comp),
        .dac_o(dac), .dout_o(dout), .doe_o(doe), .pd_o(pd)
    );

    sadc_serial_if #(.REPLAY(1'b0)) uut_z (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .dclk_i(dclk), .comp_i(comp_z),
        .dac_o(dac_z), .dout_o(dout_z), .doe_o(doe_z), .pd_o(pd_z)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One full data-clock pulse: high phase, then the fall, then settle.
    task automatic pulse();
        dclk = 1'b1;
        repeat (6) @(negedge clk);
        dclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic select();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 doe", int'(doe), 0);
        chk("R1 pd", int'(pd), 1);
        chk("R1 dout", int'(dout), 0);
        chk("R1 dac", int'(dac), 0);
    endtask

    // Full session: word, replay or zeros tail, then deselect.
    task automatic t_full(input logic [11:0] v);
        vin = v;
        select();
        chk("R8 pd low when selected", int'(pd), 0);
        pulse();
        chk("R2 enable after fall 1", int'(doe), 0);
        for (int k = 2; k <= 14; k++) begin
            pulse();
            if (k == 2) begin
                chk("R3 enable", int'(doe), 1);
                chk("R3 null bit", int'(dout), 0);
            end else begin
                chk("R4 data bit", int'(dout), int'(v[14-k]));
            end
            if (k <= 13)
                chk("R5 trial code", int'(dac),
                    (int'(v >> (14-k)) << (14-k)) | (1 << (13-k)));
            else
                chk("R5 final code", int'(dac), int'(v));
        end
        for (int k = 15; k <= 28; k++) begin
            pulse();
            chk("R6 tail", int'(dout), (k <= 25) ? int'(v[k-14]) : 0);
            chk("R7 tail zero", int'(dout_z), 0);
        end
        deselect();
        chk("R8 enable off", int'(doe), 0);
        chk("R8 pd", int'(pd), 1);
        chk("R8 enable off z", int'(doe_z), 0);
    endtask

    // Short cycle after fall 6: b11..b8 decided, b7 pending.
    task automatic t_short();
        vin = 12'hB37;
        select();
        for (int k = 1; k <= 6; k++) pulse();
        chk("R9 before abort", int'(dac), 12'hB00 | 12'h080);
        deselect();
        chk("R9 kept upper bits", int'(dac), 12'hB00);
        chk("R9 enable off", int'(doe), 0);
        vin = 12'h3C5;
        select();
        chk("R10 cleared at start", int'(dac), 0);
        pulse();
        pulse();
        chk("R10 starts at mid-scale", int'(dac), 12'h800);
        deselect();
    endtask

    task automatic t_idle_clocks();
        logic [11:0] held;
        held = dac;
        for (int k = 0; k < 5; k++) begin
            pulse();
            chk("R11 enable", int'(doe), 0);
            chk("R11 dout", int'(dout), 0);
            chk("R11 dac", int'(dac), int'(held));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full(12'hA5C);
        t_full(12'h000);
        t_full(12'hFFF);
        t_full(12'h001);
        t_full(12'h800);
        t_short();
        t_full(12'h3C5);
        t_idle_clocks();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule